// File: doc/BRIEF.md
# Split-Byte General Register Bank

This block is the register storage of a small 16-bit processor core. It keeps eight word registers: four general registers whose upper and lower bytes can each be addressed as separate 8-bit registers, and four pointer/index registers that can only be used as whole words. One write port and two independent read ports serve the datapath. Each port receives a 3-bit register specifier and a size bit that chooses word or byte access.

A byte write changes only the addressed half of its parent word. The other half keeps its value, and the parent word reflects the new byte on the next read. Byte reads deliver the selected half on the low bits of the 16-bit read bus, with the upper bits forced to zero. Writes take effect on the rising clock edge and reads are combinational. A read of the register being written in the same cycle therefore returns the value from before the write.

Top module: `gpr_bank`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears all eight registers to 0x0000, and they read as zero afterwards on both read ports.
- R2: With `wr_en` high and `wr_byte` low, the whole `wr_data` word is stored at the rising edge. Word specifiers 0..7 name registers A, C, D, B, SP, BP, SI, DI in that order.
- R3: A byte write (`wr_byte` high) with specifier 0..3 stores `wr_data[7:0]` into the low byte of A, C, D or B respectively. The high byte of that register is unchanged.
- R4: A byte write with specifier 4..7 stores `wr_data[7:0]` into the high byte of A, C, D or B respectively, ignoring `wr_data[15:8]`. The low byte of that register is unchanged.
- R5: A byte read (size bit high) with specifier 0..3 returns the low byte of A, C, D or B, and 4..7 returns the high byte. In both cases bits 15:8 of the read bus are zero.
- R6: A word read returns the full 16-bit register, including any byte written earlier into either of its halves.
- R7: A read in the same cycle as a write to the same register returns the pre-write value, with no forwarding.
- R8: With `wr_en` low, no register changes, whatever the other write inputs are.
- R9: The two read ports operate independently, each with its own specifier and size selection, in the same cycle.
- R10: Byte writes never change SP, BP, SI or DI.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write enable |
| wr_sel | input | 3 | Write register specifier |
| wr_byte | input | 1 | Write size: 0 word, 1 byte |
| wr_data | input | 16 | Write data; byte writes use bits 7:0 |
| ra_sel | input | 3 | Read port A specifier |
| ra_byte | input | 1 | Read port A size: 0 word, 1 byte |
| ra_data | output | 16 | Read port A data |
| rb_sel | input | 3 | Read port B specifier |
| rb_byte | input | 1 | Read port B size: 0 word, 1 byte |
| rb_data | output | 16 | Read port B data |

## Verification
Directed sequences write a word, then overwrite one half of it, then read it back as a word and as each byte. This separates correct lane merging from full-word overwrite and from writing the wrong half. Byte writes with junk in the upper data bits show whether the low data byte is the one routed into a high half. A byte write whose specifier matches a pointer register's word number tells aliasing to A..B apart from wrongly hitting SP..DI. Seeded random mixes of word and byte writes, disabled writes and dual reads, checked before each edge, expose forwarding, port crosstalk and stale-lane errors.

// File: rtl/gpr_bank_pkg.sv
package gpr_bank_pkg;
  typedef enum logic {SZ_WORD = 1'b0, SZ_BYTE = 1'b1} size_e;
endpackage

// File: rtl/gpr_cell.sv
module gpr_cell #(
  parameter int DATA_W = 16,
  localparam int HALF_W = DATA_W / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we_lo,
  input  logic              we_hi,
  input  logic [HALF_W-1:0] lo_d,
  input  logic [HALF_W-1:0] hi_d,
  output logic [DATA_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else begin
      if (we_lo) q[HALF_W-1:0]      <= lo_d;
      if (we_hi) q[DATA_W-1:HALF_W] <= hi_d;
    end
  end

  assert_reset_clear_R1: assert property (@(posedge clk) rst |=> q == '0);
  assert_lo_lane_R3: assert property (@(posedge clk) disable iff (rst)
    we_lo |=> q[HALF_W-1:0] == $past(lo_d));
  assert_hi_keep_R3: assert property (@(posedge clk) disable iff (rst)
    !we_hi |=> $stable(q[DATA_W-1:HALF_W]));
  assert_lo_keep_R4: assert property (@(posedge clk) disable iff (rst)
    !we_lo |=> $stable(q[HALF_W-1:0]));
endmodule

// File: rtl/gpr_wdec.sv
module gpr_wdec
  import gpr_bank_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int NUM_REGS  = 8,
  parameter int NUM_SPLIT = 4,
  localparam int HALF_W  = DATA_W / 2,
  localparam int SEL_W   = $clog2(NUM_REGS),
  localparam int SPLIT_W = $clog2(NUM_SPLIT)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [SEL_W-1:0]    wr_sel,
  input  logic                wr_byte,
  input  logic [DATA_W-1:0]   wr_data,
  output logic [NUM_REGS-1:0] we_lo,
  output logic [NUM_REGS-1:0] we_hi,
  output logic [HALF_W-1:0]   lo_d,
  output logic [HALF_W-1:0]   hi_d
);
  logic [NUM_REGS-1:0] reg_touched;

  always_comb begin
    we_lo = '0;
    we_hi = '0;
    if (wr_en) begin
      if (wr_byte == SZ_BYTE) begin
        if (wr_sel[SPLIT_W]) we_hi[wr_sel[SPLIT_W-1:0]] = 1'b1;
        else                 we_lo[wr_sel[SPLIT_W-1:0]] = 1'b1;
      end else begin
        we_lo[wr_sel] = 1'b1;
        we_hi[wr_sel] = 1'b1;
      end
    end
  end

  // a byte always comes from the low data lane, whichever half it lands in
  assign lo_d = wr_data[HALF_W-1:0];
  assign hi_d = (wr_byte == SZ_BYTE) ? wr_data[HALF_W-1:0] : wr_data[DATA_W-1:HALF_W];
  assign reg_touched = we_lo | we_hi;

  assert_one_target_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(reg_touched));
  assert_idle_no_write_R8: assert property (@(posedge clk) disable iff (rst)
    !wr_en |-> reg_touched == '0);
  assert_ptr_untouched_R10: assert property (@(posedge clk) disable iff (rst)
    wr_byte |-> reg_touched[NUM_REGS-1:NUM_SPLIT] == '0);
endmodule

// File: rtl/gpr_rport.sv
module gpr_rport
  import gpr_bank_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int NUM_REGS  = 8,
  parameter int NUM_SPLIT = 4,
  localparam int HALF_W  = DATA_W / 2,
  localparam int SEL_W   = $clog2(NUM_REGS),
  localparam int SPLIT_W = $clog2(NUM_SPLIT)
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [NUM_REGS-1:0][DATA_W-1:0] regs,
  input  logic [SEL_W-1:0]                rd_sel,
  input  logic                            rd_byte,
  output logic [DATA_W-1:0]               rd_data
);
  logic [DATA_W-1:0] parent;

  assign parent = regs[rd_sel[SPLIT_W-1:0]];

  always_comb begin
    rd_data = '0;
    if (rd_byte == SZ_BYTE) begin
      rd_data[HALF_W-1:0] = rd_sel[SPLIT_W] ? parent[DATA_W-1:HALF_W] : parent[HALF_W-1:0];
    end else begin
      rd_data = regs[rd_sel];
    end
  end

  assert_byte_zext_R5: assert property (@(posedge clk) disable iff (rst)
    rd_byte |-> rd_data[DATA_W-1:HALF_W] == '0);
endmodule

// File: rtl/gpr_bank.sv
module gpr_bank #(
  parameter int DATA_W    = 16,
  parameter int NUM_REGS  = 8,
  parameter int NUM_SPLIT = 4,
  localparam int HALF_W = DATA_W / 2,
  localparam int SEL_W  = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic              wr_byte,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [SEL_W-1:0]  ra_sel,
  input  logic              ra_byte,
  output logic [DATA_W-1:0] ra_data,
  input  logic [SEL_W-1:0]  rb_sel,
  input  logic              rb_byte,
  output logic [DATA_W-1:0] rb_data
);
  logic [NUM_REGS-1:0]             we_lo, we_hi;
  logic [HALF_W-1:0]               lo_d, hi_d;
  logic [NUM_REGS-1:0][DATA_W-1:0] regs_q;

  gpr_wdec #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .NUM_SPLIT(NUM_SPLIT)) u_wdec (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_byte(wr_byte),
    .wr_data(wr_data), .we_lo(we_lo), .we_hi(we_hi), .lo_d(lo_d), .hi_d(hi_d)
  );

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    gpr_cell #(.DATA_W(DATA_W)) u_cell (
      .clk(clk), .rst(rst), .we_lo(we_lo[i]), .we_hi(we_hi[i]),
      .lo_d(lo_d), .hi_d(hi_d), .q(regs_q[i])
    );
  end

  gpr_rport #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .NUM_SPLIT(NUM_SPLIT)) u_rport_a (
    .clk(clk), .rst(rst), .regs(regs_q), .rd_sel(ra_sel), .rd_byte(ra_byte), .rd_data(ra_data)
  );

  gpr_rport #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .NUM_SPLIT(NUM_SPLIT)) u_rport_b (
    .clk(clk), .rst(rst), .regs(regs_q), .rd_sel(rb_sel), .rd_byte(rb_byte), .rd_data(rb_data)
  );
endmodule

// File: tb/gpr_bank_test.sv
module gpr_bank_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic        wr_byte = 1'b0;
  logic [15:0] wr_data = '0;
  logic [2:0]  ra_sel = '0, rb_sel = '0;
  logic        ra_byte = 1'b0, rb_byte = 1'b0;
  logic [15:0] ra_data, rb_data;

  int n_checks = 0;
  int n_fail = 0;
  logic [15:0] model [8];

  always #5 clk = ~clk;

  gpr_bank uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_byte(wr_byte),
    .wr_data(wr_data), .ra_sel(ra_sel), .ra_byte(ra_byte), .ra_data(ra_data),
    .rb_sel(rb_sel), .rb_byte(rb_byte), .rb_data(rb_data)
  );

  function automatic logic [15:0] expect_rd(logic [2:0] s, logic b);
    if (!b) return model[s];
    if (s >= 3'd4) return {8'h00, model[s - 3'd4][15:8]};
    return {8'h00, model[s][7:0]};
  endfunction

  task automatic model_wr(logic [2:0] s, logic b, logic [15:0] d);
    if (!b) model[s] = d;
    else if (s >= 3'd4) model[s - 3'd4] = {d[7:0], model[s - 3'd4][7:0]};
    else model[s] = {model[s][15:8], d[7:0]};
  endtask

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; wr_en = 1'b0;
    @(posedge clk);
    #1;
    rst = 1'b0;
    for (int i = 0; i < 8; i++) model[i] = 16'h0000;
  endtask

  // drives a write, checks pre-edge read of the same register (R7), then lets the edge fire
  task automatic do_wr(logic en, logic [2:0] s, logic b, logic [15:0] d);
    @(negedge clk);
    wr_en = en; wr_sel = s; wr_byte = b; wr_data = d;
    ra_sel = s; ra_byte = b; rb_sel = s; rb_byte = 1'b0;
    #1;
    chk("R7 same-cycle read returns old", ra_data, expect_rd(s, b));
    @(posedge clk);
    if (en) model_wr(s, b, d);
  endtask

  task automatic do_rd(string tag, logic [2:0] sa, logic ba, logic [2:0] sb, logic bb);
    @(negedge clk);
    wr_en = 1'b0;
    ra_sel = sa; ra_byte = ba; rb_sel = sb; rb_byte = bb;
    #1;
    chk({tag, " port A"}, ra_data, expect_rd(sa, ba));
    chk({tag, " port B"}, rb_data, expect_rd(sb, bb));
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    int seed;
    seed = 32'h5EED;
    void'($urandom(seed));
    do_reset();
    // R1: everything zero after reset
    for (int i = 0; i < 8; i += 2) do_rd("R1 reset clear", 3'(i), 1'b0, 3'(i + 1), 1'b0);

    // R2/R5: word write to A then split reads
    do_wr(1'b1, 3'd0, 1'b0, 16'h1234);
    do_rd("R2 word write A", 3'd0, 1'b0, 3'd4, 1'b1);
    do_rd("R5 byte read AL zext", 3'd0, 1'b1, 3'd0, 1'b0);
    // R4: AH write with junk upper data
    do_wr(1'b1, 3'd4, 1'b1, 16'hFFAB);
    do_rd("R4 AH merge", 3'd0, 1'b0, 3'd4, 1'b1);
    chk("R6 word sees AH", ra_data, 16'hAB34);
    // R3: BL write
    do_wr(1'b1, 3'd3, 1'b0, 16'h5566);
    do_wr(1'b1, 3'd3, 1'b1, 16'hC377);
    do_rd("R3 BL merge", 3'd3, 1'b0, 3'd7, 1'b1);
    chk("R3 B word value", ra_data, 16'h5577);
    // R10: SP shares word number 4 with AH byte specifier
    do_wr(1'b1, 3'd4, 1'b0, 16'hBEEF);
    do_wr(1'b1, 3'd4, 1'b1, 16'h0011);
    do_rd("R10 SP untouched", 3'd4, 1'b0, 3'd0, 1'b0);
    chk("R10 SP value", ra_data, 16'hBEEF);
    chk("R4 A after AH", rb_data, 16'h1134);
    // R8: disabled write
    do_wr(1'b0, 3'd1, 1'b0, 16'hDEAD);
    do_rd("R8 no write when disabled", 3'd1, 1'b0, 3'd5, 1'b0);
    chk("R8 C still zero", ra_data, 16'h0000);
    // R7 explicitly: write DI, read before edge
    do_wr(1'b1, 3'd7, 1'b0, 16'h0F0F);
    do_rd("R9 two ports", 3'd7, 1'b0, 3'd3, 1'b1);

    // R9 and all: seeded random mix
    for (int it = 0; it < 400; it++) begin
      logic [2:0] s, sa, sb;
      logic b, ba, bb, en;
      logic [15:0] d;
      s = 3'($urandom); b = 1'($urandom); d = 16'($urandom);
      en = ($urandom % 4) != 0;
      sa = 3'($urandom); ba = 1'($urandom); sb = 3'($urandom); bb = 1'($urandom);
      @(negedge clk);
      wr_en = en; wr_sel = s; wr_byte = b; wr_data = d;
      ra_sel = sa; ra_byte = ba; rb_sel = sb; rb_byte = bb;
      #1;
      chk("R9 random port A", ra_data, expect_rd(sa, ba));
      chk("R9 random port B", rb_data, expect_rd(sb, bb));
      @(posedge clk);
      if (en) model_wr(s, b, d);
    end

    // R1: reset mid-run clears again
    do_reset();
    for (int i = 0; i < 8; i += 2) do_rd("R1 second reset", 3'(i), 1'b0, 3'(i + 1), 1'b1);
    summary();
  end
endmodule